// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This block executes single load and store operations against a 256-byte data memory that lives inside it. Each request carries an operation code, a 32-bit base value, a 32-bit displacement word and 32-bit store data. The unit adds the base to the sign-extended low 16 bits of the displacement. The low 8 bits of that sum select the first byte. It then reads or writes one, two or four consecutive bytes, least significant byte first.

Loads are fully combinational and answer in the same cycle. A byte or halfword result is either sign-extended or zero-extended to 32 bits. A store commits on the rising clock edge of the cycle in which it is presented. Any access width may start at any byte address. Bytes that would fall past address 255 continue at address 0.

The request side is a valid/ready stream. The unit never applies back-pressure: `req_ready` is held high, so every cycle in which `req_valid` is high is an accepted request. The response is presented in that same cycle. It carries no ready, and the requester must take it while its request is still on the bus.

Top module: `lsu_byte_mem`

## Requirements
- R1: After reset every memory byte is zero, so any load returns 0 until a store has been made.
- R2: The effective byte address is (base + sign-extended disp[15:0]) modulo 256. Displacement bits 31:16 and base bits above bit 7 have no effect on the address.
- R3: Operation 46 (signed byte load) returns the addressed byte with bit 7 copied into bits 31:8.
- R4: Operation 47 (unsigned byte load) returns the addressed byte with bits 31:8 zero.
- R5: Operation 48 (signed halfword load) returns byte A in bits 7:0 and byte A+1 in bits 15:8, with bit 15 copied into bits 31:16.
- R6: Operation 49 (unsigned halfword load) returns the same 16 bits as operation 48, with bits 31:16 zero.
- R7: Operation 50 (word load) returns bytes A, A+1, A+2 and A+3 in bits 7:0, 15:8, 23:16 and 31:24.
- R8: Operation 51 (byte store) writes wdata[7:0] to byte A and leaves every other byte unchanged.
- R9: Operations 52 and 53 (halfword stores) each write wdata[7:0] to byte A and wdata[15:8] to byte A+1, with identical effect.
- R10: Operation 54 (word store) writes wdata[7:0], [15:8], [23:16] and [31:24] to bytes A to A+3.
- R11: Accesses need no alignment. A multi-byte access that starts near address 255 continues at address 0.
- R12: The memory is left unchanged by a cycle with req_valid low, by a load, and by an operation code outside 46..54. Such a cycle drives rsp_valid low and rsp_data to 0, except for a valid load.
- R13: req_ready is always high. rsp_valid is high exactly in a cycle with req_valid high and a load code (46..50).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the memory |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; the unit accepts every request |
| req_op | input | 8 | Operation code (46..54) |
| req_base | input | 32 | Base address value |
| req_disp | input | 32 | Displacement word; only bits 15:0 are used, as a signed value |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load result valid, same cycle as the request |
| rsp_data | output | 32 | Extended load result; 0 when rsp_valid is low |

## Verification
The bench fills bytes with words whose every byte differs and whose high bits are set. A lane swap, a missing sign extension or a sign extension on an unsigned load therefore shows up as a wrong value. A negative displacement with junk in its upper 16 bits catches an address adder that does not sign-extend or that uses the whole word. A word store starting at byte 254 and the loads that follow it catch a design that clamps or drops the bytes past 255 instead of wrapping to 0. Byte and halfword stores over a fully written word catch a design that writes more lanes than the access width. Stores with valid low and undefined operation codes catch a memory that commits without a real store.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [7:0] {
    OP_LDB  = 8'd46,
    OP_LDBU = 8'd47,
    OP_LDH  = 8'd48,
    OP_LDHU = 8'd49,
    OP_LDW  = 8'd50,
    OP_STB  = 8'd51,
    OP_STH  = 8'd52,
    OP_STHU = 8'd53,
    OP_STW  = 8'd54
  } lsu_op_e;

  function automatic logic op_is_load(input logic [7:0] op);
    return (op >= OP_LDB) && (op <= OP_LDW);
  endfunction

  function automatic logic op_is_store(input logic [7:0] op);
    return (op >= OP_STB) && (op <= OP_STW);
  endfunction

  // Number of bytes a store moves
  function automatic int store_bytes(input logic [7:0] op);
    case (op)
      OP_STB:          return 1;
      OP_STH, OP_STHU: return 2;
      OP_STW:          return 4;
      default:         return 0;
    endcase
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = DATA_W - DISP_W;

  logic [DATA_W-1:0] disp_sx;
  logic [DATA_W-1:0] sum;
  logic              unused_hi;

  assign disp_sx   = {{EXT_W{disp[DISP_W-1]}}, disp[DISP_W-1:0]};
  assign sum       = base + disp_sx;
  assign ea        = sum[ADDR_W-1:0];
  // Upper sum and displacement bits do not reach the byte address
  assign unused_hi = ^{sum[DATA_W-1:ADDR_W], disp[DATA_W-1:DISP_W]};
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path import lsu_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic                       valid,
  input  logic [7:0]                 op,
  input  logic [DATA_W/8-1:0][7:0]   lane_rd,
  output logic                       ld_valid,
  output logic [DATA_W-1:0]          ld_data
);
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] word;
  assign word     = lane_rd;
  assign ld_valid = valid && op_is_load(op);

  always_comb begin
    ld_data = '0;
    if (ld_valid) begin
      case (op)
        OP_LDB:  ld_data = {{(DATA_W-8){word[7]}}, word[7:0]};
        OP_LDBU: ld_data = {{(DATA_W-8){1'b0}}, word[7:0]};
        OP_LDH:  ld_data = {{(DATA_W-HALF_W){word[HALF_W-1]}}, word[HALF_W-1:0]};
        OP_LDHU: ld_data = {{(DATA_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
        default: ld_data = word;
      endcase
    end
  end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path import lsu_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic                       valid,
  input  logic [7:0]                 op,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W/8-1:0]        lane_en,
  output logic [DATA_W/8-1:0][7:0]   lane_wd
);
  localparam int LANES = DATA_W / 8;

  logic st_fire;
  int   nbytes;

  assign st_fire = valid && op_is_store(op);
  assign nbytes  = store_bytes(op);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_en[k] = st_fire && (k < nbytes);
    assign lane_wd[k] = wdata[8*k +: 8];
  end
endmodule

// File: rtl/lsu_byte_mem.sv
module lsu_byte_mem import lsu_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_op,
  input  logic [DATA_W-1:0] req_base,
  input  logic [DATA_W-1:0] req_disp,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [DEPTH-1:0][7:0]            mem_q;
  logic [ADDR_W-1:0]                ea;
  logic [LANES-1:0][ADDR_W-1:0]     lane_addr;
  logic [LANES-1:0][7:0]            lane_rd;
  logic [LANES-1:0]                 lane_en;
  logic [LANES-1:0][7:0]            lane_wd;

  assign req_ready = 1'b1;

  lsu_agen #(.DATA_W(DATA_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_agen (
    .base(req_base), .disp(req_disp), .ea(ea)
  );

  // Consecutive byte lanes, wrapping modulo the memory size
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = ea + ADDR_W'(k);
    assign lane_rd[k]   = mem_q[lane_addr[k]];
  end

  lsu_load_path #(.DATA_W(DATA_W)) u_ld (
    .valid(req_valid), .op(req_op), .lane_rd(lane_rd),
    .ld_valid(rsp_valid), .ld_data(rsp_data)
  );

  lsu_store_path #(.DATA_W(DATA_W)) u_st (
    .valid(req_valid), .op(req_op), .wdata(req_wdata),
    .lane_en(lane_en), .lane_wd(lane_wd)
  );

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
    logic       hit;
    logic [7:0] nxt;
    always_comb begin
      hit = 1'b0;
      nxt = mem_q[gi];
      for (int k = 0; k < LANES; k++) begin
        if (lane_en[k] && (lane_addr[k] == ADDR_W'(gi))) begin
          hit = 1'b1;
          nxt = lane_wd[k];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[gi] <= 8'h00;
      else if (hit) mem_q[gi] <= nxt;
    end
  end

  logic st_fire;
  assign st_fire = req_valid && op_is_store(req_op);

  assert_store_low_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> mem_q[$past(ea)] == $past(req_wdata[7:0]));

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !st_fire |=> $stable(mem_q));

  assert_ldb_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_op == OP_LDB) |-> rsp_data[DATA_W-1:8] == {(DATA_W-8){rsp_data[7]}});

  assert_ldbu_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_op == OP_LDBU) |-> rsp_data[DATA_W-1:8] == '0);

  assert_rsp_needs_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_valid && req_ready));
endmodule

// File: tb/sim_lsu_byte_mem.sv
module sim_lsu_byte_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_op = 8'd0;
  logic [31:0] req_base = '0, req_disp = '0, req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  lsu_byte_mem u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_disp(req_disp),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] addr_of(input logic [31:0] b, input logic [31:0] d);
    logic [31:0] s;
    s = b + {{16{d[15]}}, d[15:0]};
    return s[7:0];
  endfunction

  function automatic logic [7:0] mb(input logic [7:0] a, input int off);
    logic [7:0] x;
    x = a + 8'(off);
    return model[x];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] op, input logic [31:0] b,
                      input logic [31:0] d, input logic [31:0] wd, input string tag);
    logic [7:0]  a;
    logic        ev;
    logic [31:0] ed;
    @(negedge clk);
    req_valid = v; req_op = op; req_base = b; req_disp = d; req_wdata = wd;
    #2;
    a  = addr_of(b, d);
    ev = v && (op >= 8'd46) && (op <= 8'd50);
    ed = 32'h0;
    if (ev) begin
      case (op)
        8'd46: ed = {{24{mb(a,0)[7]}}, mb(a,0)};
        8'd47: ed = {24'h0, mb(a,0)};
        8'd48: ed = {{16{mb(a,1)[7]}}, mb(a,1), mb(a,0)};
        8'd49: ed = {16'h0, mb(a,1), mb(a,0)};
        default: ed = {mb(a,3), mb(a,2), mb(a,1), mb(a,0)};
      endcase
    end
    chk({tag, " ready R13"}, {31'h0, req_ready}, 32'h1);
    chk({tag, " rsp_valid R13"}, {31'h0, rsp_valid}, {31'h0, ev});
    chk({tag, " data"}, rsp_data, ed);
    @(posedge clk);
    #1;
    if (v) begin
      case (op)
        8'd51: model[a] = wd[7:0];
        8'd52, 8'd53: begin model[a] = wd[7:0]; model[8'(a+1)] = wd[15:8]; end
        8'd54: for (int k = 0; k < 4; k++) model[8'(a+8'(k))] = wd[8*k +: 8];
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset contents
    step(1, 8'd50, 32'h0, 32'h0, 0, "R1 ldw@00");
    step(1, 8'd50, 32'h64, 32'h0, 0, "R1 ldw@64");
    step(1, 8'd50, 32'hFF, 32'h0, 0, "R1 ldw@FF");
    // R12: store with valid low, undefined codes
    step(0, 8'd54, 32'h10, 32'h0, 32'hFFFFFFFF, "R12 novalid");
    step(1, 8'd0,  32'h10, 32'h0, 32'hFFFFFFFF, "R12 op0");
    step(1, 8'd55, 32'h10, 32'h0, 32'hFFFFFFFF, "R12 op55");
    step(1, 8'd50, 32'h10, 32'h0, 0, "R12 readback");
    // R10, R7: word store and loads
    step(1, 8'd54, 32'h10, 32'h0, 32'h8899AABB, "R10 stw");
    step(1, 8'd50, 32'h10, 32'h0, 0, "R7 ldw");
    step(1, 8'd47, 32'h10, 32'h0, 0, "R10 ldbu lane0");
    step(1, 8'd46, 32'h11, 32'h0, 0, "R3 ldb");
    step(1, 8'd47, 32'h11, 32'h0, 0, "R4 ldbu");
    step(1, 8'd48, 32'h12, 32'h0, 0, "R5 ldh");
    step(1, 8'd49, 32'h12, 32'h0, 0, "R6 ldhu");
    step(1, 8'd46, 32'h10, 32'h3, 0, "R3 ldb positive? top");
    // R8: byte store inside a full word
    step(1, 8'd54, 32'h20, 32'h0, 32'hF1F2F3F4, "R8 fill");
    step(1, 8'd51, 32'h20, 32'h1, 32'h1234567F, "R8 stb");
    step(1, 8'd50, 32'h20, 32'h0, 0, "R8 ldw");
    // R9, R2: halfword stores with negative displacement and junk upper bits
    step(1, 8'd54, 32'h30, 32'h0, 32'hE1E2E3E4, "R9 fill");
    step(1, 8'd52, 32'h32, 32'h5A5AFFFE, 32'hDEADBEEF, "R9 sth R2");
    step(1, 8'd50, 32'h30, 32'h0, 0, "R9 ldw sth");
    step(1, 8'd53, 32'h42, 32'h0000FFFE, 32'hDEADBEEF, "R9 sthu");
    step(1, 8'd50, 32'h40, 32'h0, 0, "R9 ldw sthu");
    // R2: high base bits and positive 16-bit displacement
    step(1, 8'd54, 32'h12345600, 32'hABCD7FFF, 32'h11223344, "R2 stw wrap");
    step(1, 8'd50, 32'hFF, 32'h0, 0, "R2 ldw@FF");
    // R11: unaligned and wrap past the end
    step(1, 8'd54, 32'hFE, 32'h0, 32'hCAFEF00D, "R11 stw@FE");
    step(1, 8'd50, 32'hFE, 32'h0, 0, "R11 ldw@FE");
    step(1, 8'd49, 32'hFF, 32'h0, 0, "R11 ldhu@FF");
    step(1, 8'd48, 32'hFF, 32'h0, 0, "R11 ldh@FF");
    step(1, 8'd50, 32'h0, 32'h0, 0, "R11 ldw@00");
    step(1, 8'd50, 32'h13, 32'h0, 0, "R11 ldw@13 unaligned");
    step(1, 8'd49, 32'h21, 32'h0, 0, "R11 ldhu@21");
    step(0, 8'd50, 32'h10, 32'h0, 0, "R12 idle load");
    finish_run();
  end
endmodule